// File: doc/BRIEF.md
# Page-versus-Buffer Compare Engine

This block is the compare path of a serial page-organised flash device. A host selects it by pulling the active-low chip select low, then clocks a 32-bit command frame in on a serial data input, most significant bit first, with bits taken on the rising edge of the serial clock. A compare command names one page of the main array. When chip select returns high, the engine checks every byte of that page against the matching byte of the single page buffer. It works in the background on the system clock at one byte pair per cycle, and it reports busy while the check runs. At the end it records a single mismatch flag in the status byte.

The host learns the outcome by polling. A status-read command returns a status byte on the serial output. That byte carries a ready flag and the mismatch flag. A plain fill port lets the surrounding device (or a bench) place bytes into the main array and into the buffer. The serial pins are oversampled by the system clock through two-stage synchronisers, so the serial clock must run well below the system clock.

Top module: `pageCmpEngine`

## Requirements
- R1: After reset the status byte reads 0x80: the ready flag is set and the mismatch flag is clear.
- R2: A status read is the opcode 0xD7 followed by eight more serial clocks. The status byte comes out MSB first on `so`, one bit for each of the serial rising edges 9 to 16. Bit 7 is ready (1 = idle), bit 6 is the mismatch flag, and bits 5..0 read 0.
- R3: A compare frame has four parts, in order. First the opcode 0x60 in bits 31..24. Then six reserved bits. Then a 9-bit page number in frame bits 17..9. Then nine ignored bits. The low log2(NUM_PAGES) bits of the page number choose the page.
- R4: A compare starts only when chip select rises. It does not start on the last serial clock. From that point the status byte reports busy (bit 7 = 0).
- R5: Busy lasts exactly PAGE_BYTES system clock cycles, one for each byte pair.
- R6: Bit 6 becomes 0 when all PAGE_BYTES byte pairs are equal. It becomes 1 when any pair differs, including only the first or only the last byte.
- R7: Bit 6 changes only at the end of a compare. It keeps its value across status reads until the next compare finishes.
- R8: A frame that holds other than exactly 32 serial clocks when chip select rises is discarded. Nothing starts, and bit 6 is unchanged.
- R9: A compare frame that completes while a compare is running is ignored. The running compare keeps its page and its result.
- R10: A full 32-bit frame with any opcode other than 0x60 starts nothing.
- R11: A pulse on `fillEn` writes `fillData`. With `fillToBuf` = 0 it goes into the main array at byte address page*PAGE_BYTES + offset. With `fillToBuf` = 1 it goes into the buffer at offset `fillAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, rising edge samples `si` |
| si | input | 1 | Serial data in, MSB first |
| so | output | 1 | Serial data out (status byte) |
| fillEn | input | 1 | Write strobe for the fill port |
| fillToBuf | input | 1 | 1 selects the page buffer, 0 the main array |
| fillAddr | input | MAIN_AW | Byte address of the fill write |
| fillData | input | 8 | Byte written by the fill port |

## Verification
Two things can overlap in time. The first is the busy background walk. The second is the serial front end, which keeps decoding new frames during the walk. The bench checks both ways this can happen. First, it issues a status read right after launching a compare and expects the ready bit clear. Second, it launches a matching compare and then, at a faster serial rate, sends a second compare for a differing page that completes before the walk is over. The final status must show a match, which proves the second frame was dropped rather than queued or allowed to restart the walk.

// File: rtl/pce_pkg.sv
`timescale 1ns/1ps
package pce_pkg;
  localparam logic [7:0] OP_COMPARE = 8'h60;
  localparam logic [7:0] OP_STATUS  = 8'hD7;
  localparam int         FRAME_BITS = 32;
  localparam int         PAGE_FIRST = 14;   // serial index of the page MSB
  localparam int         PAGE_LASTB = 22;   // serial index of the page LSB

  typedef struct packed {
    logic startCmp;
    logic walkStep;
    logic walkLast;
    logic statLoad;
    logic statShift;
    logic busy;
  } ctrlStrobes_t;
endpackage

// File: rtl/pce_ctrl.sv
`timescale 1ns/1ps
module pce_ctrl
  import pce_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_AW    = 2,
  parameter int IDX_W      = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               sck,
  input  logic               si,
  output ctrlStrobes_t       strobes,
  output logic [PAGE_AW-1:0] cmdPage,
  output logic [IDX_W-1:0]   walkIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);
  localparam logic [5:0]       FULL_CNT = 6'(FRAME_BITS);

  logic [1:0] csSync;
  logic [2:0] sckSync;
  logic [1:0] siSync;
  logic       csPrev;
  logic [5:0] bitCnt;
  logic [7:0] opShift;
  logic [PAGE_AW-1:0] pageShift;
  logic       rdActive;
  logic       busy;

  logic csLow, csRise, sckRise, sckFall, siBit;
  logic statLoadW, statShiftW, startW;

  assign csLow   = ~csSync[1];
  assign csRise  = csSync[1] & ~csPrev;
  assign sckRise = sckSync[1] & ~sckSync[2];
  assign sckFall = ~sckSync[1] & sckSync[2];
  assign siBit   = siSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync  <= 2'b11;
      sckSync <= '0;
      siSync  <= '0;
      csPrev  <= 1'b1;
    end else begin
      csSync  <= {csSync[0], csN};
      sckSync <= {sckSync[1:0], sck};
      siSync  <= {siSync[0], si};
      csPrev  <= csSync[1];
    end
  end

  // Frame decode: opcode and page bits are captured by position.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      opShift   <= '0;
      pageShift <= '0;
    end else if (!csLow) begin
      bitCnt <= '0;
    end else if (sckRise) begin
      if (bitCnt != 6'h3F) bitCnt <= bitCnt + 6'd1;
      if (bitCnt < 6'd8) opShift <= {opShift[6:0], siBit};
      if (bitCnt >= 6'(PAGE_FIRST) && bitCnt <= 6'(PAGE_LASTB))
        pageShift <= PAGE_AW'({pageShift, siBit});
    end
  end

  assign statLoadW  = csLow & sckRise & (bitCnt == 6'd7) &
                      ({opShift[6:0], siBit} == OP_STATUS);
  assign statShiftW = csLow & sckFall & rdActive & (bitCnt >= 6'd9);
  assign startW     = csRise & (bitCnt == FULL_CNT) &
                      (opShift == OP_COMPARE) & ~busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdActive <= 1'b0;
    else if (!csLow)    rdActive <= 1'b0;
    else if (statLoadW) rdActive <= 1'b1;
  end

  // Background walk, one byte pair per cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      walkIdx <= '0;
    end else if (startW) begin
      busy    <= 1'b1;
      walkIdx <= '0;
    end else if (busy) begin
      if (walkIdx == LAST_IDX) busy <= 1'b0;
      else                     walkIdx <= walkIdx + 1'b1;
    end
  end

  assign cmdPage           = pageShift;
  assign strobes.startCmp  = startW;
  assign strobes.walkStep  = busy;
  assign strobes.walkLast  = busy & (walkIdx == LAST_IDX);
  assign strobes.statLoad  = statLoadW;
  assign strobes.statShift = statShiftW;
  assign strobes.busy      = busy;

  // Checker support: independent busy-length counter.
  logic [IDX_W:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == (IDX_W+1)'(PAGE_BYTES)); // R5
  AST_WALK_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(walkIdx) == LAST_IDX); // R6
  AST_START_NEEDS_FULL_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(bitCnt) == FULL_CNT && $past(csRise))); // R8
  AST_START_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csSync[1])); // R4
endmodule

// File: rtl/pce_datapath.sv
`timescale 1ns/1ps
module pce_datapath
  import pce_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_AW    = 2,
  parameter int IDX_W      = 9,
  parameter int MAIN_AW    = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [PAGE_AW-1:0] cmdPage,
  input  logic [IDX_W-1:0]   walkIdx,
  input  logic               fillEn,
  input  logic               fillToBuf,
  input  logic [MAIN_AW-1:0] fillAddr,
  input  logic [7:0]         fillData,
  output logic               so
);
  localparam int TOTAL_BYTES = NUM_PAGES * PAGE_BYTES;

  logic [7:0] mainMem [TOTAL_BYTES];
  logic [7:0] bufMem  [PAGE_BYTES];

  logic [PAGE_AW-1:0] pageReg;
  logic               diffAcc;
  logic               mismatch;
  logic [7:0]         statReg;
  logic [MAIN_AW-1:0] rdAddr;
  logic               byteDiff;

  always_ff @(posedge clk) begin
    if (fillEn) begin
      if (fillToBuf) begin
        if (fillAddr < MAIN_AW'(PAGE_BYTES)) bufMem[fillAddr[IDX_W-1:0]] <= fillData;
      end else if (fillAddr < MAIN_AW'(TOTAL_BYTES)) begin
        mainMem[fillAddr] <= fillData;
      end
    end
  end

  assign rdAddr   = MAIN_AW'(pageReg) * MAIN_AW'(PAGE_BYTES) + MAIN_AW'(walkIdx);
  assign byteDiff = mainMem[rdAddr] != bufMem[walkIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg  <= '0;
      diffAcc  <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      if (strobes.startCmp) begin
        pageReg <= cmdPage;
        diffAcc <= 1'b0;
      end else if (strobes.walkStep) begin
        diffAcc <= diffAcc | byteDiff;
      end
      if (strobes.walkLast) mismatch <= diffAcc | byteDiff;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  statReg <= '0;
    else if (strobes.statLoad)  statReg <= {~strobes.busy, mismatch, 6'b0};
    else if (strobes.statShift) statReg <= {statReg[6:0], 1'b0};
  end

  assign so = statReg[7];

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.walkLast) |-> $stable(mismatch)); // R7
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.walkStep) && strobes.walkStep) |-> $stable(pageReg)); // R9
  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.statLoad && strobes.statShift)); // R2
endmodule

// File: rtl/pageCmpEngine.sv
`timescale 1ns/1ps
module pageCmpEngine
  import pce_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 264,
  localparam int PAGE_AW   = $clog2(NUM_PAGES),
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int MAIN_AW   = $clog2(NUM_PAGES * PAGE_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               sck,
  input  logic               si,
  output logic               so,
  input  logic               fillEn,
  input  logic               fillToBuf,
  input  logic [MAIN_AW-1:0] fillAddr,
  input  logic [7:0]         fillData
);
  ctrlStrobes_t       strobes;
  logic [PAGE_AW-1:0] cmdPage;
  logic [IDX_W-1:0]   walkIdx;

  pce_ctrl #(.PAGE_BYTES(PAGE_BYTES), .PAGE_AW(PAGE_AW), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .strobes(strobes), .cmdPage(cmdPage), .walkIdx(walkIdx)
  );

  pce_datapath #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .PAGE_AW(PAGE_AW),
                 .IDX_W(IDX_W), .MAIN_AW(MAIN_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdPage(cmdPage), .walkIdx(walkIdx),
    .fillEn(fillEn), .fillToBuf(fillToBuf), .fillAddr(fillAddr), .fillData(fillData),
    .so(so)
  );
endmodule

// File: tb/pageCmpEngine_bench.sv
`timescale 1ns/1ps
module pageCmpEngine_bench;
  localparam int NP = 4;
  localparam int PB = 264;
  localparam int AW = $clog2(NP * PB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic so;
  logic fillEn = 1'b0, fillToBuf = 1'b0;
  logic [AW-1:0] fillAddr = '0;
  logic [7:0] fillData = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } expItem_t;
  expItem_t expQ[$];
  logic [7:0] lastRd;
  event rdDone;

  always #2 clk = ~clk;

  pageCmpEngine #(.NUM_PAGES(NP), .PAGE_BYTES(PB)) u_pageCmpEngine (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .so(so),
    .fillEn(fillEn), .fillToBuf(fillToBuf), .fillAddr(fillAddr), .fillData(fillData)
  );

  function automatic logic [7:0] patByte(input int p, input int i);
    return 8'(p * 29 + i * 7 + 3);
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fillByte(input bit toBuf, input int addr, input logic [7:0] d);
    @(negedge clk);
    fillEn = 1'b1; fillToBuf = toBuf; fillAddr = AW'(addr); fillData = d;
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  task automatic spiXfer(input logic [39:0] vec, input int n, input int hp,
                         output logic [7:0] rd);
    rd = '0;
    csN = 1'b0;
    waitClk(hp);
    for (int k = 0; k < n; k++) begin
      si = vec[39-k];
      waitClk(hp);
      if (k >= 8 && k < 16) rd = {rd[6:0], so};
      sck = 1'b1;
      waitClk(hp);
      sck = 1'b0;
    end
    waitClk(hp);
    csN = 1'b1;
    si = 1'b0;
    waitClk(8);
  endtask

  function automatic logic [39:0] cmpFrame(input logic [7:0] op, input logic [8:0] page);
    return {op, 6'b0, page, 9'h0, 8'h0};
  endfunction

  task automatic sendCmd(input logic [7:0] op, input logic [8:0] page,
                         input int nBits, input int hp);
    logic [7:0] unused;
    spiXfer(cmpFrame(op, page), nBits, hp, unused);
  endtask

  task automatic expectStatus(input logic [7:0] exp, input string tag);
    expItem_t it;
    logic [7:0] rd;
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    spiXfer({8'hD7, 32'h0}, 16, 4, rd);
    lastRd = rd;
    -> rdDone;
    waitClk(2);
  endtask

  // Monitor: pops expectations and compares as reads complete.
  initial begin
    forever begin
      expItem_t it;
      @(rdDone);
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty actual=%02h expected=none", lastRd);
      end else begin
        it = expQ.pop_front();
        if (lastRd !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, lastRd, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < PB; i++) fillByte(1'b0, p * PB + i, patByte(p, i));
    for (int i = 0; i < PB; i++) fillByte(1'b1, i, patByte(1, i)); // R11 buffer = page 1

    expectStatus(8'h80, "R1 reset status");

    sendCmd(8'h60, 9'd1, 32, 4);
    expectStatus(8'h00, "R4 busy right after start");
    waitClk(300);
    expectStatus(8'h80, "R6 full match");

    sendCmd(8'h60, 9'd2, 32, 4);
    waitClk(300);
    expectStatus(8'hC0, "R3 page select mismatch");
    expectStatus(8'hC0, "R7 result held over reads");

    sendCmd(8'h60, 9'd1, 32, 4);
    waitClk(300);
    expectStatus(8'h80, "R7 next compare updates bit");

    fillByte(1'b0, PB + PB - 1, ~patByte(1, PB - 1));
    sendCmd(8'h60, 9'd1, 32, 4);
    waitClk(300);
    expectStatus(8'hC0, "R6 last byte differs");
    fillByte(1'b0, PB + PB - 1, patByte(1, PB - 1));
    sendCmd(8'h60, 9'd1, 32, 4);
    waitClk(300);
    expectStatus(8'h80, "R5 walk completes after restore");

    fillByte(1'b1, 0, ~patByte(1, 0));
    sendCmd(8'h60, 9'd1, 32, 4);
    waitClk(300);
    expectStatus(8'hC0, "R11 buffer first byte differs");
    fillByte(1'b1, 0, patByte(1, 0));

    sendCmd(8'h60, 9'h101, 32, 4);
    waitClk(300);
    expectStatus(8'h80, "R3 low page bits select page 1");

    sendCmd(8'h60, 9'd2, 31, 4);
    expectStatus(8'h80, "R8 short frame no busy");
    waitClk(300);
    expectStatus(8'h80, "R8 short frame no result");
    sendCmd(8'h60, 9'd2, 33, 4);
    waitClk(300);
    expectStatus(8'h80, "R8 long frame discarded");

    sendCmd(8'h61, 9'd2, 32, 4);
    waitClk(300);
    expectStatus(8'h80, "R10 foreign opcode");

    sendCmd(8'h60, 9'd1, 32, 3);
    sendCmd(8'h60, 9'd2, 32, 3);
    waitClk(300);
    expectStatus(8'h80, "R9 compare while busy ignored");

    sendCmd(8'h60, 9'd2, 32, 4);
    waitClk(300);
    expectStatus(8'hC0, "R2 status bits after mismatch");

    waitClk(10);
    done = 1'b1;
    if (expQ.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule